// File: doc/BRIEF.md
# Chained Command and Status Queue

This block sits between a host and a packet engine inside a network controller. It lets the host post transmit and receive commands back to back, without waiting for each one to finish. Each command carries a buffer page number. There are two lanes, one for transmit and one for receive. Each lane has a two-deep command pipeline and a two-deep queue of completion events, and each event keeps the status word the engine reported with it.

After reset the block works as a plain single-command controller. Each lane holds one command, and the interrupt follows the level flags: transmitter idle and receiver idle. Setting the chaining bit in the configuration register does two things. Each lane then accepts two commands. The interrupt then follows the stored completion events, and the host retires them one at a time with a clear command. The level flags stay readable in both modes.

The packet engine takes commands from each lane in the order they were issued, one at a time. It reports each finish with a done pulse and a status word. The two lanes never interact.

Top module: `cq_chain_top`

## Requirements
- R1: After reset, chaining is off and both interrupt enables are off. `status_o` reads 8'h03, `irq_o` is 0, and neither lane requests the engine.
- R2: A configuration write stores `cfg_data` from the next cycle on. Bit 6 turns chaining on. Bit 0 enables the transmit interrupt and bit 1 enables the receive interrupt.
- R3: A lane holds at most one pending command with chaining off and at most DEPTH (2) with chaining on. The capacity check uses the count before any same-cycle retirement. A command beyond capacity is dropped and sets the lane's overflow flag (`status_o` bit 5 for transmit, bit 6 for receive). A clear command for that lane resets the flag, but a new overflow in the same cycle wins.
- R4: Each lane offers the oldest pending command that is not yet taken on `*_req_valid`/`*_req_page`. The offer is held, unchanged, until `*_req_ready` is high. After that, no new offer appears until the engine reports done.
- R5: A done pulse while a command is in flight retires that command and records an event with the done status. A done pulse with nothing in flight is ignored.
- R6: Each lane stores up to two events. An event that arrives while two are already stored is dropped and sets the lane's overflow flag.
- R7: The transition flags (`status_o` bit 3 for transmit, bit 4 for receive) are 1 exactly while the lane holds a stored event. `*_evt_stat` shows the oldest stored event's status. A clear command for a lane (`clr_is_rx` 0 = transmit, 1 = receive) discards that lane's oldest event.
- R8: The idle flags (`status_o` bit 0 for transmit, bit 1 for receive) are 1 exactly when the lane has no pending command. This holds in both modes.
- R9: The last-result flags (`status_o` bit 2 for transmit, bit 7 for receive) are cleared when a command is accepted into an empty lane. On a completion they are loaded with bit 0 of the done status.
- R10: With chaining on, `irq_o` is the OR over both lanes of (enable AND transition flag). With chaining off, it is the OR over both lanes of (enable AND idle flag).
- R11: Commands, clears, handshakes and completions of one lane never change the other lane's flags, events or engine request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration value: bit 6 chaining, bit 1 receive interrupt enable, bit 0 transmit interrupt enable |
| cmd_valid | input | 1 | Host command strobe |
| cmd_is_rx | input | 1 | Command lane: 0 transmit, 1 receive |
| cmd_page | input | PAGE_W | Buffer page of the command |
| clr_valid | input | 1 | Interrupt-clear strobe |
| clr_is_rx | input | 1 | Clear lane: 0 transmit, 1 receive |
| status_o | output | 8 | Status register, bits as given in R3, R7, R8, R9 |
| tx_evt_stat | output | STAT_W | Status of the oldest stored transmit event |
| rx_evt_stat | output | STAT_W | Status of the oldest stored receive event |
| irq_o | output | 1 | Interrupt |
| tx_req_valid | output | 1 | Transmit command offered to the engine |
| tx_req_page | output | PAGE_W | Page of the offered transmit command |
| tx_req_ready | input | 1 | Engine takes the transmit command |
| tx_done | input | 1 | Transmit completion pulse |
| tx_done_stat | input | STAT_W | Transmit completion status |
| rx_req_valid | output | 1 | Receive command offered to the engine |
| rx_req_page | output | PAGE_W | Page of the offered receive command |
| rx_req_ready | input | 1 | Engine takes the receive command |
| rx_done | input | 1 | Receive completion pulse |
| rx_done_stat | input | STAT_W | Receive completion status |

## Verification
The bench covers several corner cases, each tied to a specific way the design could go wrong.

- A second command in single-command mode. A design with the wrong capacity would accept the command, and the overflow flag would stay clear.
- A third command after chaining is switched on.
- A done pulse with nothing in flight. A design that does not gate done with the in-flight state would record a phantom event.
- A completion that meets two stored events while a clear pops one in the same cycle. A design that tests fullness after the pop would keep the event instead of flagging overflow.
- Random mode switches while a lane holds two commands. A design that re-derives capacity wrongly would accept or lose commands.
- Interleaved traffic on both lanes, which would expose any event or flag leaking across lanes.

// File: rtl/cq_pkg.sv
package cq_pkg;
    typedef enum logic {LANE_TX = 1'b0, LANE_RX = 1'b1} lane_e;

    localparam int CFG_TXEN_BIT  = 0;
    localparam int CFG_RXEN_BIT  = 1;
    localparam int CFG_CHAIN_BIT = 6;

    localparam int ST_TX_IDLE = 0;
    localparam int ST_RX_IDLE = 1;
    localparam int ST_TX_LAST = 2;
    localparam int ST_TX_EVT  = 3;
    localparam int ST_RX_EVT  = 4;
    localparam int ST_TX_OVF  = 5;
    localparam int ST_RX_OVF  = 6;
    localparam int ST_RX_LAST = 7;

    typedef struct packed {
        logic chain;
        logic en_rx;
        logic en_tx;
    } cfg_t;

    typedef struct packed {
        logic idle;
        logic evt;
        logic ovf;
        logic last_ok;
    } lane_flags_t;

    function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                             int unsigned depth);
        int unsigned s;
        s = base + off;
        if (s >= depth) s = s - depth;
        return s;
    endfunction
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          full,
    output logic          empty
);
    import cq_pkg::*;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic [PW-1:0] wr_idx;
    logic          push_ok, pop_ok;

    assign full    = (cnt >= cap);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_comb begin
        wr_idx = PW'(ring_add(int'(rd_ptr), int'(cnt), DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_ok) mem[wr_idx] <= din;
            if (pop_ok) rd_ptr <= PW'(ring_add(int'(rd_ptr), 1, DEPTH));
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/cq_lane.sv
module cq_lane #(
    parameter int PAGE_W = 4,
    parameter int STAT_W = 4,
    parameter int DEPTH  = 2,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chain,
    input  logic              cmd_push,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              clr,
    output logic              req_valid,
    output logic [PAGE_W-1:0] req_page,
    input  logic              req_ready,
    input  logic              done,
    input  logic [STAT_W-1:0] done_stat,
    output logic              idle,
    output logic              evt_valid,
    output logic [STAT_W-1:0] evt_stat,
    output logic              ovf,
    output logic              last_ok
);
    logic          inflight;
    logic          done_ok;
    logic          cmd_full, cmd_empty;
    logic          evt_full, evt_empty;
    logic [CW-1:0] cmd_cap;

    assign cmd_cap   = chain ? CW'(DEPTH) : CW'(1);
    assign done_ok   = done && inflight;
    assign idle      = cmd_empty;
    assign evt_valid = !evt_empty;
    assign req_valid = !cmd_empty && !inflight;

    cq_fifo #(.W(PAGE_W), .DEPTH(DEPTH)) cmd_q (
        .clk(clk), .rst(rst), .cap(cmd_cap),
        .push(cmd_push), .din(cmd_page), .pop(done_ok),
        .head(req_page), .full(cmd_full), .empty(cmd_empty)
    );

    cq_fifo #(.W(STAT_W), .DEPTH(DEPTH)) evt_q (
        .clk(clk), .rst(rst), .cap(CW'(DEPTH)),
        .push(done_ok), .din(done_stat), .pop(clr),
        .head(evt_stat), .full(evt_full), .empty(evt_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= 1'b0;
            ovf      <= 1'b0;
            last_ok  <= 1'b0;
        end else begin
            if (done_ok)                       inflight <= 1'b0;
            else if (req_valid && req_ready)   inflight <= 1'b1;

            if ((cmd_push && cmd_full) || (done_ok && evt_full)) ovf <= 1'b1;
            else if (clr)                                          ovf <= 1'b0;

            if (done_ok)                       last_ok <= done_stat[0];
            else if (cmd_push && cmd_empty)    last_ok <= 1'b0;
        end
    end
endmodule

// File: rtl/cq_chain_top.sv
module cq_chain_top #(
    parameter int PAGE_W = 4,
    parameter int STAT_W = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    input  logic              cmd_valid,
    input  logic              cmd_is_rx,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              clr_valid,
    input  logic              clr_is_rx,
    output logic [7:0]        status_o,
    output logic [STAT_W-1:0] tx_evt_stat,
    output logic [STAT_W-1:0] rx_evt_stat,
    output logic              irq_o,
    output logic              tx_req_valid,
    output logic [PAGE_W-1:0] tx_req_page,
    input  logic              tx_req_ready,
    input  logic              tx_done,
    input  logic [STAT_W-1:0] tx_done_stat,
    output logic              rx_req_valid,
    output logic [PAGE_W-1:0] rx_req_page,
    input  logic              rx_req_ready,
    input  logic              rx_done,
    input  logic [STAT_W-1:0] rx_done_stat
);
    import cq_pkg::*;

    localparam int NLANE = 2;

    cfg_t        cfg_q;
    lane_flags_t flags [NLANE];
    logic [NLANE-1:0] req_v;
    logic [PAGE_W-1:0] req_p [NLANE];
    logic [STAT_W-1:0] ev_s  [NLANE];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.chain <= cfg_data[CFG_CHAIN_BIT];
            cfg_q.en_rx <= cfg_data[CFG_RXEN_BIT];
            cfg_q.en_tx <= cfg_data[CFG_TXEN_BIT];
        end
    end

    for (genvar d = 0; d < NLANE; d++) begin : g_lane
        localparam lane_e LN = lane_e'(d);
        cq_lane #(.PAGE_W(PAGE_W), .STAT_W(STAT_W), .DEPTH(DEPTH)) lane_i (
            .clk       (clk),
            .rst       (rst),
            .chain     (cfg_q.chain),
            .cmd_push  (cmd_valid && (cmd_is_rx == LN)),
            .cmd_page  (cmd_page),
            .clr       (clr_valid && (clr_is_rx == LN)),
            .req_valid (req_v[d]),
            .req_page  (req_p[d]),
            .req_ready ((LN == LANE_RX) ? rx_req_ready : tx_req_ready),
            .done      ((LN == LANE_RX) ? rx_done : tx_done),
            .done_stat ((LN == LANE_RX) ? rx_done_stat : tx_done_stat),
            .idle      (flags[d].idle),
            .evt_valid (flags[d].evt),
            .evt_stat  (ev_s[d]),
            .ovf       (flags[d].ovf),
            .last_ok   (flags[d].last_ok)
        );
    end

    assign tx_req_valid = req_v[LANE_TX];
    assign rx_req_valid = req_v[LANE_RX];
    assign tx_req_page  = req_p[LANE_TX];
    assign rx_req_page  = req_p[LANE_RX];
    assign tx_evt_stat  = ev_s[LANE_TX];
    assign rx_evt_stat  = ev_s[LANE_RX];

    always_comb begin
        status_o             = '0;
        status_o[ST_TX_IDLE] = flags[LANE_TX].idle;
        status_o[ST_RX_IDLE] = flags[LANE_RX].idle;
        status_o[ST_TX_LAST] = flags[LANE_TX].last_ok;
        status_o[ST_RX_LAST] = flags[LANE_RX].last_ok;
        status_o[ST_TX_EVT]  = flags[LANE_TX].evt;
        status_o[ST_RX_EVT]  = flags[LANE_RX].evt;
        status_o[ST_TX_OVF]  = flags[LANE_TX].ovf;
        status_o[ST_RX_OVF]  = flags[LANE_RX].ovf;
    end

    always_comb begin
        if (cfg_q.chain)
            irq_o = (cfg_q.en_tx && flags[LANE_TX].evt) || (cfg_q.en_rx && flags[LANE_RX].evt);
        else
            irq_o = (cfg_q.en_tx && flags[LANE_TX].idle) || (cfg_q.en_rx && flags[LANE_RX].idle);
    end
endmodule

// File: rtl/cq_chain_checker.sv
module cq_chain_checker #(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_is_rx,
    input logic [7:0]        status_o,
    input logic              tx_req_valid,
    input logic [PAGE_W-1:0] tx_req_page,
    input logic              tx_req_ready,
    input logic              tx_done,
    input logic              rx_done
);
    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req_valid && !tx_req_ready) |=> (tx_req_valid && $stable(tx_req_page)));

    // R4
    offer_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req_valid |-> !status_o[0]);

    // R7
    tx_evt_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[3]) |-> $past(tx_done));

    // R7
    rx_evt_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[4]) |-> $past(rx_done));

    // R8
    idle_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[0]) |-> $past(cmd_valid && !cmd_is_rx));

    // R3
    tx_ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[5]) |-> ($past(cmd_valid && !cmd_is_rx) || $past(tx_done)));
endmodule

bind cq_chain_top cq_chain_checker #(.PAGE_W(PAGE_W)) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_rx(cmd_is_rx),
    .status_o(status_o), .tx_req_valid(tx_req_valid), .tx_req_page(tx_req_page),
    .tx_req_ready(tx_req_ready), .tx_done(tx_done), .rx_done(rx_done)
);

// File: tb/cq_chain_tb.sv
module cq_chain_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W = 4;
    localparam int STAT_W = 4;
    localparam int DEPTH  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0;  logic [7:0] cfg_data = 0;
    logic cmd_valid = 0, cmd_is_rx = 0; logic [PAGE_W-1:0] cmd_page = 0;
    logic clr_valid = 0, clr_is_rx = 0;
    logic [7:0] status_o; logic [STAT_W-1:0] tx_evt_stat, rx_evt_stat;
    logic irq_o;
    logic tx_req_valid, rx_req_valid; logic [PAGE_W-1:0] tx_req_page, rx_req_page;
    logic [1:0] rdy = 0, dn = 0;
    logic [STAT_W-1:0] dstat [2];

    int checks = 0, failures = 0;
    bit finished = 0;

    // reference state
    int  cq [2][4]; int cqn [2]; bit infl [2];
    int  eq [2][4]; int eqn [2]; bit ovf [2]; bit lok [2];
    bit  chain; bit en [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cq_chain_top #(.PAGE_W(PAGE_W), .STAT_W(STAT_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cmd_valid(cmd_valid), .cmd_is_rx(cmd_is_rx), .cmd_page(cmd_page),
        .clr_valid(clr_valid), .clr_is_rx(clr_is_rx), .status_o(status_o),
        .tx_evt_stat(tx_evt_stat), .rx_evt_stat(rx_evt_stat), .irq_o(irq_o),
        .tx_req_valid(tx_req_valid), .tx_req_page(tx_req_page), .tx_req_ready(rdy[0]),
        .tx_done(dn[0]), .tx_done_stat(dstat[0]),
        .rx_req_valid(rx_req_valid), .rx_req_page(rx_req_page), .rx_req_ready(rdy[1]),
        .rx_done(dn[1]), .rx_done_stat(dstat[1])
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            cqn[d] = 0; eqn[d] = 0; infl[d] = 0; ovf[d] = 0; lok[d] = 0; en[d] = 0;
        end
        chain = 0;
    endtask

    task automatic model_step();
        for (int d = 0; d < 2; d++) begin
            int cap; bit cmd_d, clr_d, done_ok, handoff, cfull, efull, idle_b, ne;
            cap     = chain ? DEPTH : 1;
            cmd_d   = cmd_valid && (int'(cmd_is_rx) == d);
            clr_d   = clr_valid && (int'(clr_is_rx) == d);
            done_ok = dn[d] && infl[d];
            handoff = (cqn[d] > 0) && !infl[d] && rdy[d];
            cfull   = cqn[d] >= cap;
            efull   = eqn[d] >= DEPTH;
            idle_b  = cqn[d] == 0;
            ne      = eqn[d] > 0;
            if ((cmd_d && cfull) || (done_ok && efull)) ovf[d] = 1;
            else if (clr_d) ovf[d] = 0;
            if (done_ok) lok[d] = dstat[d][0];
            else if (cmd_d && idle_b) lok[d] = 0;
            if (done_ok) infl[d] = 0; else if (handoff) infl[d] = 1;
            if (done_ok) begin
                for (int i = 0; i < 3; i++) cq[d][i] = cq[d][i+1];
                cqn[d]--;
            end
            if (cmd_d && !cfull) begin cq[d][cqn[d]] = int'(cmd_page); cqn[d]++; end
            if (clr_d && ne) begin
                for (int i = 0; i < 3; i++) eq[d][i] = eq[d][i+1];
                eqn[d]--;
            end
            if (done_ok && !efull) begin eq[d][eqn[d]] = int'(dstat[d]); eqn[d]++; end
        end
        if (cfg_wr) begin chain = cfg_data[6]; en[0] = cfg_data[0]; en[1] = cfg_data[1]; end
    endtask

    function automatic logic [7:0] exp_status();
        return {lok[1], ovf[1], ovf[0], eqn[1] > 0, eqn[0] > 0, lok[0], cqn[1] == 0, cqn[0] == 0};
    endfunction

    function automatic bit exp_irq();
        if (chain) return (en[0] && eqn[0] > 0) || (en[1] && eqn[1] > 0);
        return (en[0] && cqn[0] == 0) || (en[1] && cqn[1] == 0);
    endfunction

    task automatic compare_all();
        logic [7:0] e;
        e = exp_status();
        chk(status_o[1:0] == e[1:0], "R8 idle flags", status_o[1:0], e[1:0]);
        chk({status_o[7], status_o[2]} == {e[7], e[2]}, "R9 last-result",
            {status_o[7], status_o[2]}, {e[7], e[2]});
        chk(status_o[4:3] == e[4:3], "R7 transition flags", status_o[4:3], e[4:3]);
        chk(status_o[6:5] == e[6:5], "R3 R6 overflow", status_o[6:5], e[6:5]);
        chk(irq_o == exp_irq(), "R10 irq", irq_o, exp_irq());
        chk(tx_req_valid == (cqn[0] > 0 && !infl[0]), "R4 tx offer", tx_req_valid, cqn[0] > 0 && !infl[0]);
        chk(rx_req_valid == (cqn[1] > 0 && !infl[1]), "R4 rx offer", rx_req_valid, cqn[1] > 0 && !infl[1]);
        if (cqn[0] > 0) chk(int'(tx_req_page) == cq[0][0], "R4 tx page order", tx_req_page, cq[0][0]);
        if (cqn[1] > 0) chk(int'(rx_req_page) == cq[1][0], "R4 rx page order", rx_req_page, cq[1][0]);
        if (eqn[0] > 0) chk(int'(tx_evt_stat) == eq[0][0], "R7 tx event status", tx_evt_stat, eq[0][0]);
        if (eqn[1] > 0) chk(int'(rx_evt_stat) == eq[1][0], "R7 rx event status", rx_evt_stat, eq[1][0]);
    endtask

    task automatic quiet();
        cfg_wr = 0; cmd_valid = 0; clr_valid = 0; rdy = 0; dn = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        #1;
        if (!rst) compare_all();
        quiet();
    endtask

    task automatic send_cmd(input bit rx, input int page);
        cmd_valid = 1; cmd_is_rx = rx; cmd_page = PAGE_W'(page);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        dstat[0] = 0; dstat[1] = 0;
        model_reset();
        repeat (3) cycle();
        rst = 0;
        #1;
        // R1 reset state
        chk(status_o == 8'h03, "R1 status after reset", status_o, 8'h03);
        chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
        chk(!tx_req_valid && !rx_req_valid, "R1 no engine request", {tx_req_valid, rx_req_valid}, 0);

        // single-command mode: second tx command dropped (R3)
        send_cmd(0, 5); cycle();
        send_cmd(0, 6); cycle();
        chk(status_o[5] == 1'b1, "R3 second command ignored sets overflow", status_o[5], 1);
        chk(tx_req_page == 4'd5, "R3 dropped command not queued", tx_req_page, 5);
        // R11: rx lane untouched by tx traffic
        chk(status_o[1] == 1'b1 && !rx_req_valid, "R11 rx lane unaffected",
            {status_o[1], rx_req_valid}, 2'b10);
        // R5: done with nothing in flight ignored
        dn[0] = 1; dstat[0] = 4'h1; cycle();
        chk(status_o[3] == 1'b0, "R5 stray done ignored", status_o[3], 0);
        rdy[0] = 1; cycle();
        dn[0] = 1; dstat[0] = 4'h9; cycle();
        chk(status_o[3] && tx_evt_stat == 4'h9, "R5 completion recorded",
            {status_o[3], tx_evt_stat}, 5'h19);
        clr_valid = 1; clr_is_rx = 0; cycle();
        chk(status_o[5] == 1'b0 && status_o[3] == 1'b0, "R3 R7 clear pops and resets overflow",
            status_o[6:3], 0);

        // R2: chaining on with both enables
        cfg_wr = 1; cfg_data = 8'h43; cycle();
        send_cmd(0, 1); cycle();
        send_cmd(1, 2); cycle();
        send_cmd(0, 3); cycle();
        chk(status_o[5] == 1'b0, "R2 chaining allows two commands", status_o[5], 0);
        send_cmd(0, 4); cycle();
        chk(status_o[5] == 1'b1, "R3 third command overflows", status_o[5], 1);
        chk(status_o[6] == 1'b0, "R11 rx overflow unaffected", status_o[6], 0);
        // drain two tx completions, then third completion meets full queue with a clear (R6)
        for (int k = 0; k < 2; k++) begin
            rdy[0] = 1; cycle();
            dn[0] = 1; dstat[0] = 4'(k + 2); cycle();
        end
        send_cmd(0, 7); cycle();
        rdy[0] = 1; cycle();
        dn[0] = 1; dstat[0] = 4'hF; clr_valid = 1; clr_is_rx = 0; cycle();
        chk(status_o[5] == 1'b1, "R6 event dropped when two stored", status_o[5], 1);
        chk(tx_evt_stat == 4'h3, "R6 R7 oldest remaining event", tx_evt_stat, 3);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 100 < 4) begin
                cfg_wr = 1; cfg_data = 8'($urandom) & 8'h43;
            end
            if ($urandom % 100 < 35) send_cmd(1'($urandom), int'($urandom % 16));
            if ($urandom % 100 < 20) begin clr_valid = 1; clr_is_rx = 1'($urandom); end
            rdy = 2'($urandom);
            dn[0] = ($urandom % 100 < 30); dn[1] = ($urandom % 100 < 30);
            dstat[0] = STAT_W'($urandom); dstat[1] = STAT_W'($urandom);
            cycle();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule